// File: doc/BRIEF.md
# Dual-Path Prioritized Interrupt Controller

This block collects fifteen maskable interrupt requests and one nonmaskable request. Each request is held in a pending register until it is serviced. A per-source enable bit gates each request, and the block chooses the highest-priority source that is ready to be serviced. A per-source route bit then sends the winner to one of two service paths. The standard path is an ordinary vectored software handler. The transfer path is a microcoded data-transfer engine that has its own vector table. Each path has its own global enable.

The block issues a call only at an instruction boundary. The call is a one-cycle strobe that carries the vector address, the path and the source index. After a call, after the standard path is globally enabled, and after a save-and-clear of the enables, the next instruction boundary is skipped so that one instruction always runs. When the transfer engine reports that the count for a channel has run out, the block clears that channel's route bit. If the standard path is enabled, the block also raises an end-of-transfer request. A save port places the enable state on a bus and clears it in a single cycle, and a restore port reloads it.

Top module: `irq_dual_ctrl`

## Requirements
- R1: After reset, the enables, route bits, pending bits, both global enables and the inhibit are all zero. `call_o`, `eot_req_o` and `save_bus_o` read zero.
- R2: A maskable source whose enable bit is 0 is never called. Its pending bit stays set, and the source is called once its enable bit is written to 1.
- R3: A winner with route bit 0 is called with `call_path_o`=0 and vector 0x2000+2*index. A winner with route bit 1 is called with `call_path_o`=1 and vector 0x2040+2*index.
- R4: Among the eligible sources, the one with the highest index wins. Index 14 is the highest maskable priority.
- R5: A source on the standard path is eligible only while the standard global enable is set. A source on the transfer path needs only the transfer global enable, whatever the state of the standard enable. An ineligible source does not block a lower-index eligible source.
- R6: A high `req_i` bit sets its pending bit, and the bit stays set until the source is called. The bit clears on the same edge that issues the call, unless the same source requests again in that cycle. `pend_wr_i` overwrites all pending bits.
- R7: The nonmaskable request is called with index 15, vector 0x203E and path 0. It ignores the enable bits and both global enables, and it takes precedence over every maskable source.
- R8: A `cnt_zero_i` pulse for channel k clears route bit k. The bit stays clear until software writes it, so later calls of k use the standard path.
- R9: `eot_req_o` pulses on the edge after a `cnt_zero_i` cycle, with `eot_idx_o` equal to the channel, only if the standard global enable was set in that cycle.
- R10: After a call, a standard-enable set (`std_en_set_i`) or a save, the next cycle with `instr_done_i` high issues no call. A later cycle with `instr_done_i` high may issue one.
- R11: While `save_i` is high, `save_bus_o` shows {transfer enable, standard enable, enable bits}, and the edge then clears all of them. `restore_i` loads them from `restore_data_i` without adding an inhibit.
- R12: `call_o` is a one-cycle pulse on the edge after a cycle in which `instr_done_i` is high, no inhibit is pending and an eligible source exists.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 15 | Maskable request pulses, bit = source index |
| nmi_req_i | input | 1 | Nonmaskable request pulse |
| mask_wr_i | input | 1 | Write strobe for the enable bits |
| mask_wdata_i | input | 15 | Enable bit data |
| sel_wr_i | input | 1 | Write strobe for the route bits |
| sel_wdata_i | input | 15 | Route bit data, 1 = transfer path |
| pend_wr_i | input | 1 | Write strobe for the pending bits |
| pend_wdata_i | input | 15 | Pending bit data |
| std_en_set_i | input | 1 | Set the standard global enable (adds inhibit) |
| std_en_clr_i | input | 1 | Clear the standard global enable |
| xfr_en_set_i | input | 1 | Set the transfer global enable |
| xfr_en_clr_i | input | 1 | Clear the transfer global enable |
| save_i | input | 1 | Save and clear the enables (adds inhibit) |
| restore_i | input | 1 | Reload the enables from restore_data_i |
| restore_data_i | input | 17 | {transfer enable, standard enable, enable bits} |
| cnt_zero_i | input | 1 | Transfer count of a channel reached zero |
| cnt_zero_idx_i | input | 4 | Channel whose count reached zero |
| instr_done_i | input | 1 | Instruction boundary |
| call_o | output | 1 | One-cycle call strobe |
| call_path_o | output | 1 | 0 = standard path, 1 = transfer path |
| call_idx_o | output | 4 | Called source, 15 = nonmaskable |
| call_vec_o | output | 16 | Vector address of the call |
| eot_req_o | output | 1 | End-of-transfer request pulse |
| eot_idx_o | output | 4 | Channel of the end-of-transfer request |
| save_bus_o | output | 17 | {transfer enable, standard enable, enable bits} |

## Verification
A wrong pending, route or enable bit shows at the ports as a vector or path error on the next call that bit affects. It can also show as a missing call or an extra call, one edge after the cycle with `instr_done_i` high. The bench brings each bit out through a call, sweeping every source on both paths. An inhibit flag stuck set suppresses every later call. An inhibit flag that clears too early lets a call appear at the boundary right after a call, an enable or a save. The route-bit clear is observed within two boundaries, through the path of the next call of that channel. The end-of-transfer gate is observed on the edge after the `cnt_zero_i` pulse.

// File: rtl/irq_ctl_pkg.sv
// Package: shared types for the dual-path interrupt controller.
// Assumes: nothing beyond IEEE 1800-2017.
package irq_ctl_pkg;

    // Service path of a call.
    typedef enum logic {
        PATH_STD = 1'b0,
        PATH_XFR = 1'b1
    } irq_path_e;

endpackage

// File: rtl/irq_cfg_regs.sv
// Module: enable bits, route bits and the two global enables, plus the
// save/restore and count-zero clear of route bits.
// Assumes: save_i has priority over restore_i, and restore_i over the
// individual writes; a count-zero clear wins over a same-cycle route write.
module irq_cfg_regs #(
    parameter int NUM_SRC = 15,
    parameter int IDX_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               mask_wr_i,
    input  logic [NUM_SRC-1:0] mask_wdata_i,
    input  logic               sel_wr_i,
    input  logic [NUM_SRC-1:0] sel_wdata_i,
    input  logic               std_en_set_i,
    input  logic               std_en_clr_i,
    input  logic               xfr_en_set_i,
    input  logic               xfr_en_clr_i,
    input  logic               save_i,
    input  logic               restore_i,
    input  logic [NUM_SRC+1:0] restore_data_i,
    input  logic               cnt_zero_i,
    input  logic [IDX_W-1:0]   cnt_zero_idx_i,
    output logic [NUM_SRC-1:0] mask_q,
    output logic [NUM_SRC-1:0] sel_q,
    output logic               std_en_q,
    output logic               xfr_en_q,
    output logic [NUM_SRC+1:0] save_bus_o
);

    logic [NUM_SRC-1:0] zero_dec;
    logic [NUM_SRC-1:0] sel_d;

    // Decode the channel whose transfer count ran out.
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_zero_dec
        assign zero_dec[k] = cnt_zero_i && (cnt_zero_idx_i == IDX_W'(k));
    end

    // Next route bits: a software write, then the hardware clear on count zero.
    always_comb begin
        sel_d = sel_wr_i ? sel_wdata_i : sel_q;
        sel_d = sel_d & ~zero_dec;
    end

    // Route bit register.
    always_ff @(posedge clk) begin
        if (!rst_n) sel_q <= '0;
        else        sel_q <= sel_d;
    end

    // Enable bits with save-clear and restore.
    always_ff @(posedge clk) begin
        if (!rst_n)         mask_q <= '0;
        else if (save_i)    mask_q <= '0;
        else if (restore_i) mask_q <= restore_data_i[NUM_SRC-1:0];
        else if (mask_wr_i) mask_q <= mask_wdata_i;
    end

    // Standard-path global enable.
    always_ff @(posedge clk) begin
        if (!rst_n)            std_en_q <= 1'b0;
        else if (save_i)       std_en_q <= 1'b0;
        else if (restore_i)    std_en_q <= restore_data_i[NUM_SRC];
        else if (std_en_set_i) std_en_q <= 1'b1;
        else if (std_en_clr_i) std_en_q <= 1'b0;
    end

    // Transfer-path global enable.
    always_ff @(posedge clk) begin
        if (!rst_n)            xfr_en_q <= 1'b0;
        else if (save_i)       xfr_en_q <= 1'b0;
        else if (restore_i)    xfr_en_q <= restore_data_i[NUM_SRC+1];
        else if (xfr_en_set_i) xfr_en_q <= 1'b1;
        else if (xfr_en_clr_i) xfr_en_q <= 1'b0;
    end

    assign save_bus_o = {xfr_en_q, std_en_q, mask_q};

    // R8
    sel_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_zero_i |=> ((sel_q & $past(zero_dec)) == '0));

    // R11
    save_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        save_i |=> (mask_q == '0) && !std_en_q && !xfr_en_q);

endmodule

// File: rtl/irq_pend_regs.sv
// Module: pending latches for the maskable sources and the nonmaskable source.
// Assumes: the clear vector is one-hot or zero; a request in the same cycle
// as its clear keeps the bit set.
module irq_pend_regs #(
    parameter int NUM_SRC = 15
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] req_i,
    input  logic               nmi_req_i,
    input  logic               pend_wr_i,
    input  logic [NUM_SRC-1:0] pend_wdata_i,
    input  logic [NUM_SRC-1:0] clr_vec_i,
    input  logic               nmi_clr_i,
    output logic [NUM_SRC-1:0] pend_q,
    output logic               nmi_pend_q
);

    logic [NUM_SRC-1:0] pend_d;

    // Next pending bits: write, then the service clear, then new requests.
    always_comb begin
        pend_d = pend_wr_i ? pend_wdata_i : pend_q;
        pend_d = (pend_d & ~clr_vec_i) | req_i;
    end

    // Maskable pending register.
    always_ff @(posedge clk) begin
        if (!rst_n) pend_q <= '0;
        else        pend_q <= pend_d;
    end

    // Nonmaskable pending latch.
    always_ff @(posedge clk) begin
        if (!rst_n) nmi_pend_q <= 1'b0;
        else        nmi_pend_q <= (nmi_pend_q & ~nmi_clr_i) | nmi_req_i;
    end

    // R6
    req_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (req_i != '0) |=> ((pend_q & $past(req_i)) == $past(req_i)));

    // R7
    nmi_latch_chk: assert property (@(posedge clk) disable iff (!rst_n)
        nmi_req_i |=> nmi_pend_q);

endmodule

// File: rtl/irq_prio_pick.sv
// Module: eligibility and priority selection. The highest index eligible
// source wins; a pending nonmaskable request overrides all of them.
// Assumes: all inputs are register outputs (no combinational loop back).
module irq_prio_pick
    import irq_ctl_pkg::*;
#(
    parameter int NUM_SRC = 15,
    parameter int IDX_W   = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] pend_i,
    input  logic [NUM_SRC-1:0] mask_i,
    input  logic [NUM_SRC-1:0] sel_i,
    input  logic               std_en_i,
    input  logic               xfr_en_i,
    input  logic               nmi_pend_i,
    output logic               win_valid_o,
    output logic [IDX_W-1:0]   win_idx_o,
    output logic [NUM_SRC-1:0] win_oh_o,
    output irq_path_e          win_path_o,
    output logic               win_nmi_o
);

    localparam logic [IDX_W-1:0] NMI_IDX = IDX_W'(NUM_SRC);

    logic [NUM_SRC-1:0] elig;

    // Per-source eligibility: pending, enabled and its path globally on.
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_elig
        assign elig[k] = pend_i[k] & mask_i[k] & (sel_i[k] ? xfr_en_i : std_en_i);
    end

    // Winner index, scanning upward so the last hit is the highest index.
    always_comb begin
        win_valid_o = nmi_pend_i;
        win_idx_o   = NMI_IDX;
        if (!nmi_pend_i) begin
            win_idx_o = '0;
            for (int k = 0; k < NUM_SRC; k++) begin
                if (elig[k]) begin
                    win_valid_o = 1'b1;
                    win_idx_o   = IDX_W'(k);
                end
            end
        end
    end

    // One-hot grant, scanning downward and blocking below the first hit.
    always_comb begin
        logic seen;
        seen     = nmi_pend_i;
        win_oh_o = '0;
        for (int k = NUM_SRC - 1; k >= 0; k--) begin
            win_oh_o[k] = elig[k] & ~seen;
            seen        = seen | elig[k];
        end
    end

    assign win_nmi_o  = nmi_pend_i;
    assign win_path_o = (!nmi_pend_i && ((win_oh_o & sel_i) != '0)) ? PATH_XFR : PATH_STD;

    // R4
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(win_oh_o) && (win_valid_o == ((win_oh_o != '0) || nmi_pend_i)));

endmodule

// File: rtl/irq_call_seq.sv
// Module: call sequencer. Issues the call at an instruction boundary,
// keeps the one-instruction inhibit, forms the vector and raises the
// end-of-transfer request.
// Assumes: instr_done_i is high for one cycle per completed instruction.
module irq_call_seq
    import irq_ctl_pkg::*;
#(
    parameter int              NUM_SRC  = 15,
    parameter int              IDX_W    = 4,
    parameter int              VEC_W    = 16,
    parameter logic [VEC_W-1:0] STD_BASE = 16'h2000,
    parameter logic [VEC_W-1:0] XFR_BASE = 16'h2040,
    parameter logic [VEC_W-1:0] NMI_VEC  = 16'h203E
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             instr_done_i,
    input  logic             std_en_set_i,
    input  logic             save_i,
    input  logic             win_valid_i,
    input  logic [IDX_W-1:0] win_idx_i,
    input  irq_path_e        win_path_i,
    input  logic             win_nmi_i,
    input  logic             std_en_i,
    input  logic             cnt_zero_i,
    input  logic [IDX_W-1:0] cnt_zero_idx_i,
    output logic             fire_o,
    output logic             call_o,
    output irq_path_e        call_path_o,
    output logic [IDX_W-1:0] call_idx_o,
    output logic [VEC_W-1:0] call_vec_o,
    output logic             eot_req_o,
    output logic [IDX_W-1:0] eot_idx_o
);

    localparam logic [VEC_W-1:0] XFR_END = XFR_BASE + VEC_W'(2 * NUM_SRC);

    logic             inhib_q;
    logic [VEC_W-1:0] vec_d;

    // Call decision: boundary, no inhibit, nothing that sets one now.
    assign fire_o = win_valid_i & instr_done_i & ~inhib_q & ~std_en_set_i & ~save_i;

    // Vector address of the current winner.
    always_comb begin
        if (win_nmi_i)                vec_d = NMI_VEC;
        else if (win_path_i == PATH_XFR) vec_d = XFR_BASE + (VEC_W'(win_idx_i) << 1);
        else                          vec_d = STD_BASE + (VEC_W'(win_idx_i) << 1);
    end

    // One-instruction inhibit after a call, a standard enable or a save.
    always_ff @(posedge clk) begin
        if (!rst_n)                              inhib_q <= 1'b0;
        else if (fire_o || std_en_set_i || save_i) inhib_q <= 1'b1;
        else if (instr_done_i)                   inhib_q <= 1'b0;
    end

    // Call strobe.
    always_ff @(posedge clk) begin
        if (!rst_n) call_o <= 1'b0;
        else        call_o <= fire_o;
    end

    // Call attributes, held until the next call.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            call_path_o <= PATH_STD;
            call_idx_o  <= '0;
            call_vec_o  <= '0;
        end else if (fire_o) begin
            call_path_o <= win_path_i;
            call_idx_o  <= win_idx_i;
            call_vec_o  <= vec_d;
        end
    end

    // End-of-transfer request, gated by the standard global enable.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            eot_req_o <= 1'b0;
            eot_idx_o <= '0;
        end else begin
            eot_req_o <= cnt_zero_i & std_en_i;
            if (cnt_zero_i) eot_idx_o <= cnt_zero_idx_i;
        end
    end

    // R10
    no_back2back_chk: assert property (@(posedge clk) disable iff (!rst_n)
        call_o |=> !call_o);

    // R10
    inhibit_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
        call_o |-> !$past(save_i) && !$past(std_en_set_i));

    // R12
    boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
        call_o |-> $past(instr_done_i));

    // R3
    xfr_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_o && call_path_o == PATH_XFR) |-> (call_vec_o >= XFR_BASE) && (call_vec_o < XFR_END));

    // R9
    eot_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        eot_req_o |-> $past(std_en_i) && $past(cnt_zero_i));

endmodule

// File: rtl/irq_dual_ctrl.sv
// Module: top of the dual-path prioritized interrupt controller. Wires the
// configuration registers, pending latches, priority picker and call
// sequencer together.
// Assumes: synchronous active-low reset; one instruction boundary pulse per
// completed instruction.
module irq_dual_ctrl
    import irq_ctl_pkg::*;
#(
    parameter int              NUM_SRC  = 15,
    parameter int              VEC_W    = 16,
    parameter logic [VEC_W-1:0] STD_BASE = 16'h2000,
    parameter logic [VEC_W-1:0] XFR_BASE = 16'h2040,
    parameter logic [VEC_W-1:0] NMI_VEC  = 16'h203E
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic [NUM_SRC-1:0]           req_i,
    input  logic                         nmi_req_i,
    input  logic                         mask_wr_i,
    input  logic [NUM_SRC-1:0]           mask_wdata_i,
    input  logic                         sel_wr_i,
    input  logic [NUM_SRC-1:0]           sel_wdata_i,
    input  logic                         pend_wr_i,
    input  logic [NUM_SRC-1:0]           pend_wdata_i,
    input  logic                         std_en_set_i,
    input  logic                         std_en_clr_i,
    input  logic                         xfr_en_set_i,
    input  logic                         xfr_en_clr_i,
    input  logic                         save_i,
    input  logic                         restore_i,
    input  logic [NUM_SRC+1:0]           restore_data_i,
    input  logic                         cnt_zero_i,
    input  logic [$clog2(NUM_SRC+1)-1:0] cnt_zero_idx_i,
    input  logic                         instr_done_i,
    output logic                         call_o,
    output logic                         call_path_o,
    output logic [$clog2(NUM_SRC+1)-1:0] call_idx_o,
    output logic [VEC_W-1:0]             call_vec_o,
    output logic                         eot_req_o,
    output logic [$clog2(NUM_SRC+1)-1:0] eot_idx_o,
    output logic [NUM_SRC+1:0]           save_bus_o
);

    localparam int IDX_W = $clog2(NUM_SRC + 1);

    logic [NUM_SRC-1:0] mask_q, sel_q, pend_q, win_oh, clr_vec, call_dec;
    logic               std_en_q, xfr_en_q, nmi_pend_q;
    logic               win_valid, win_nmi, fire;
    logic [IDX_W-1:0]   win_idx;
    irq_path_e          win_path, call_path;

    irq_cfg_regs #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_cfg (
        .clk(clk), .rst_n(rst_n),
        .mask_wr_i(mask_wr_i), .mask_wdata_i(mask_wdata_i),
        .sel_wr_i(sel_wr_i), .sel_wdata_i(sel_wdata_i),
        .std_en_set_i(std_en_set_i), .std_en_clr_i(std_en_clr_i),
        .xfr_en_set_i(xfr_en_set_i), .xfr_en_clr_i(xfr_en_clr_i),
        .save_i(save_i), .restore_i(restore_i), .restore_data_i(restore_data_i),
        .cnt_zero_i(cnt_zero_i), .cnt_zero_idx_i(cnt_zero_idx_i),
        .mask_q(mask_q), .sel_q(sel_q), .std_en_q(std_en_q), .xfr_en_q(xfr_en_q),
        .save_bus_o(save_bus_o)
    );

    // Service clear of the winning pending bit on the call edge.
    assign clr_vec = fire ? win_oh : '0;

    irq_pend_regs #(.NUM_SRC(NUM_SRC)) u_pend (
        .clk(clk), .rst_n(rst_n),
        .req_i(req_i), .nmi_req_i(nmi_req_i),
        .pend_wr_i(pend_wr_i), .pend_wdata_i(pend_wdata_i),
        .clr_vec_i(clr_vec), .nmi_clr_i(fire & win_nmi),
        .pend_q(pend_q), .nmi_pend_q(nmi_pend_q)
    );

    irq_prio_pick #(.NUM_SRC(NUM_SRC), .IDX_W(IDX_W)) u_pick (
        .clk(clk), .rst_n(rst_n),
        .pend_i(pend_q), .mask_i(mask_q), .sel_i(sel_q),
        .std_en_i(std_en_q), .xfr_en_i(xfr_en_q), .nmi_pend_i(nmi_pend_q),
        .win_valid_o(win_valid), .win_idx_o(win_idx), .win_oh_o(win_oh),
        .win_path_o(win_path), .win_nmi_o(win_nmi)
    );

    irq_call_seq #(
        .NUM_SRC(NUM_SRC), .IDX_W(IDX_W), .VEC_W(VEC_W),
        .STD_BASE(STD_BASE), .XFR_BASE(XFR_BASE), .NMI_VEC(NMI_VEC)
    ) u_seq (
        .clk(clk), .rst_n(rst_n),
        .instr_done_i(instr_done_i), .std_en_set_i(std_en_set_i), .save_i(save_i),
        .win_valid_i(win_valid), .win_idx_i(win_idx), .win_path_i(win_path),
        .win_nmi_i(win_nmi), .std_en_i(std_en_q),
        .cnt_zero_i(cnt_zero_i), .cnt_zero_idx_i(cnt_zero_idx_i),
        .fire_o(fire), .call_o(call_o), .call_path_o(call_path),
        .call_idx_o(call_idx_o), .call_vec_o(call_vec_o),
        .eot_req_o(eot_req_o), .eot_idx_o(eot_idx_o)
    );

    assign call_path_o = (call_path == PATH_XFR);

    // Decode of the called index, used only by the checks below.
    for (genvar k = 0; k < NUM_SRC; k++) begin : g_call_dec
        assign call_dec[k] = (call_idx_o == IDX_W'(k));
    end

    // R2
    mask_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_o && call_idx_o != IDX_W'(NUM_SRC)) |-> ((call_dec & $past(mask_q)) != '0));

    // R5
    std_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_o && !call_path_o && call_idx_o != IDX_W'(NUM_SRC)) |-> $past(std_en_q));

    // R5
    xfr_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_o && call_path_o) |-> $past(xfr_en_q));

    // R7
    nmi_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (call_o && $past(nmi_pend_q)) |-> (call_idx_o == IDX_W'(NUM_SRC)));

endmodule

// File: tb/irq_dual_ctrl_tb.sv
`timescale 1ns/1ps
module irq_dual_ctrl_tb;

    localparam int N = 15;

    logic        clk = 1'b0;
    logic        rst_n;
    logic [N-1:0] req_i, mask_wdata_i, sel_wdata_i, pend_wdata_i;
    logic        nmi_req_i, mask_wr_i, sel_wr_i, pend_wr_i;
    logic        std_en_set_i, std_en_clr_i, xfr_en_set_i, xfr_en_clr_i;
    logic        save_i, restore_i, cnt_zero_i, instr_done_i;
    logic [N+1:0] restore_data_i;
    logic [3:0]  cnt_zero_idx_i;
    logic        call_o, call_path_o, eot_req_o;
    logic [3:0]  call_idx_o, eot_idx_o;
    logic [15:0] call_vec_o;
    logic [N+1:0] save_bus_o;

    int checks = 0;
    int errors = 0;

    always #2.5 clk = ~clk;

    irq_dual_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .nmi_req_i(nmi_req_i),
        .mask_wr_i(mask_wr_i), .mask_wdata_i(mask_wdata_i),
        .sel_wr_i(sel_wr_i), .sel_wdata_i(sel_wdata_i),
        .pend_wr_i(pend_wr_i), .pend_wdata_i(pend_wdata_i),
        .std_en_set_i(std_en_set_i), .std_en_clr_i(std_en_clr_i),
        .xfr_en_set_i(xfr_en_set_i), .xfr_en_clr_i(xfr_en_clr_i),
        .save_i(save_i), .restore_i(restore_i), .restore_data_i(restore_data_i),
        .cnt_zero_i(cnt_zero_i), .cnt_zero_idx_i(cnt_zero_idx_i),
        .instr_done_i(instr_done_i),
        .call_o(call_o), .call_path_o(call_path_o), .call_idx_o(call_idx_o),
        .call_vec_o(call_vec_o), .eot_req_o(eot_req_o), .eot_idx_o(eot_idx_o),
        .save_bus_o(save_bus_o)
    );

    task automatic check(input string rq, input string what, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s %s: actual %h expected %h", rq, what, act, exp);
        end
    endtask

    function automatic logic [31:0] exp_call(input logic p, input int i);
        logic [15:0] v;
        if (i == 15) v = 16'h203E;
        else         v = (p ? 16'h2040 : 16'h2000) + 16'(2 * i);
        return {10'b0, 1'b1, p, 4'(i), v};
    endfunction

    function automatic logic [31:0] got_call();
        return {10'b0, call_o, call_path_o, call_idx_o, call_vec_o};
    endfunction

    task automatic idle();
        req_i = '0; nmi_req_i = 0; mask_wr_i = 0; sel_wr_i = 0; pend_wr_i = 0;
        mask_wdata_i = '0; sel_wdata_i = '0; pend_wdata_i = '0;
        std_en_set_i = 0; std_en_clr_i = 0; xfr_en_set_i = 0; xfr_en_clr_i = 0;
        save_i = 0; restore_i = 0; restore_data_i = '0;
        cnt_zero_i = 0; cnt_zero_idx_i = '0; instr_done_i = 0;
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
        idle();
    endtask

    task automatic do_instr();
        instr_done_i = 1;
        tick();
    endtask

    // Write enables, routes, clear pending, set global enables, drop inhibit.
    task automatic cfg(input logic [N-1:0] m, input logic [N-1:0] s, input logic se, input logic xe);
        mask_wr_i = 1; mask_wdata_i = m; sel_wr_i = 1; sel_wdata_i = s;
        pend_wr_i = 1; pend_wdata_i = '0;
        std_en_set_i = se; std_en_clr_i = ~se; xfr_en_set_i = xe; xfr_en_clr_i = ~xe;
        tick();
        do_instr();
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL R12 watchdog: actual timeout expected completion");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        idle();
        rst_n = 0;
        repeat (3) @(posedge clk);
        #1 rst_n = 1;
        // R1 reset state
        check("R1", "call", {31'b0, call_o}, 0);
        check("R1", "eot", {31'b0, eot_req_o}, 0);
        check("R1", "save bus", 32'(save_bus_o), 0);
        do_instr();
        do_instr();
        check("R1", "no call after reset", {31'b0, call_o}, 0);

        // R3 R6 R10 R12: every source on both paths
        for (int i = 0; i < N; i++) begin
            for (int p = 0; p < 2; p++) begin
                cfg(N'(1) << i, p[0] ? (N'(1) << i) : '0, 1, 1);
                req_i = N'(1) << i;
                tick();
                do_instr();
                check("R3", "sweep call", got_call(), exp_call(p[0], i));
                do_instr();
                check("R10", "boundary after call", {31'b0, call_o}, 0);
                do_instr();
                check("R6", "pending cleared", {31'b0, call_o}, 0);
            end
        end

        // R4 priority order, mixed paths
        cfg('1, 15'h5555, 1, 1);
        pend_wr_i = 1; pend_wdata_i = '1;
        tick();
        for (int k = N - 1; k >= 0; k--) begin
            do_instr();
            check("R4", "priority order", got_call(), exp_call(k % 2 == 0, k));
            do_instr();
        end
        do_instr();
        check("R4", "all drained", {31'b0, call_o}, 0);

        // R5 standard path off, transfer path still served
        cfg('1, N'(1) << 5, 0, 1);
        pend_wr_i = 1; pend_wdata_i = (N'(1) << 5) | (N'(1) << 9);
        tick();
        do_instr();
        check("R5", "xfr while std off", got_call(), exp_call(1, 5));
        do_instr();
        do_instr();
        check("R5", "std source held off", {31'b0, call_o}, 0);
        std_en_set_i = 1;
        tick();
        do_instr();
        check("R10", "boundary after enable", {31'b0, call_o}, 0);
        do_instr();
        check("R5", "std source after enable", got_call(), exp_call(0, 9));
        cfg('1, N'(1) << 3, 1, 0);
        req_i = N'(1) << 3;
        tick();
        do_instr();
        check("R5", "xfr off blocks", {31'b0, call_o}, 0);

        // R2 disabled source keeps pending
        cfg('0, '0, 1, 1);
        req_i = N'(1) << 3;
        tick();
        do_instr();
        do_instr();
        check("R2", "masked no call", {31'b0, call_o}, 0);
        mask_wr_i = 1; mask_wdata_i = N'(1) << 3;
        tick();
        do_instr();
        check("R2", "call after unmask", got_call(), exp_call(0, 3));
        do_instr();

        // R7 nonmaskable
        cfg('0, '0, 0, 0);
        nmi_req_i = 1;
        tick();
        do_instr();
        check("R7", "nmi with all off", got_call(), exp_call(0, 15));
        do_instr();
        cfg('1, '0, 1, 1);
        pend_wr_i = 1; pend_wdata_i = N'(1) << 14; nmi_req_i = 1;
        tick();
        do_instr();
        check("R7", "nmi beats 14", got_call(), exp_call(0, 15));
        do_instr();
        do_instr();
        check("R7", "14 after nmi", got_call(), exp_call(0, 14));
        do_instr();

        // R8 R9 count zero
        cfg(N'(1) << 4, N'(1) << 4, 1, 1);
        cnt_zero_i = 1; cnt_zero_idx_i = 4;
        tick();
        check("R9", "eot pulse", {27'b0, eot_req_o, eot_idx_o}, {27'b0, 1'b1, 4'd4});
        tick();
        check("R9", "eot one cycle", {31'b0, eot_req_o}, 0);
        req_i = N'(1) << 4;
        tick();
        do_instr();
        check("R8", "route cleared", got_call(), exp_call(0, 4));
        do_instr();
        std_en_clr_i = 1;
        tick();
        cnt_zero_i = 1; cnt_zero_idx_i = 2;
        tick();
        check("R9", "eot gated off", {31'b0, eot_req_o}, 0);

        // R11 save and restore
        cfg('1, '0, 1, 1);
        save_i = 1;
        #1 check("R11", "save bus", 32'(save_bus_o), 32'h1FFFF);
        tick();
        check("R11", "cleared after save", 32'(save_bus_o), 0);
        req_i = N'(1) << 6;
        tick();
        do_instr();
        check("R11", "no call after save", {31'b0, call_o}, 0);
        restore_i = 1; restore_data_i = 17'h1FFFF;
        tick();
        check("R11", "restored", 32'(save_bus_o), 32'h1FFFF);
        do_instr();
        check("R11", "call after restore", got_call(), exp_call(0, 6));
        do_instr();

        // R6 same-cycle request keeps the bit
        pend_wr_i = 1; pend_wdata_i = N'(1) << 2;
        tick();
        instr_done_i = 1; req_i = N'(1) << 2;
        tick();
        check("R6", "first call", got_call(), exp_call(0, 2));
        do_instr();
        do_instr();
        check("R6", "re-request kept", got_call(), exp_call(0, 2));
        do_instr();
        do_instr();
        check("R6", "now empty", {31'b0, call_o}, 0);

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule